// File: doc/BRIEF.md
# Unmaskable Special Interrupt Unit

This unit gathers the four interrupt events that software can never mask: the stack running past its limit, a request on the non-maskable interrupt pin, a trap instruction and an instruction word that the decoder cannot execute. It presents at most one service request to the CPU at a time, together with the 24-bit address from which the CPU fetches the handler vector. The CPU takes the request by raising an acknowledge in a cycle where the request is high.

The events reach the unit by two paths. The decoder strobes for the illegal opcode and the trap instruction are captured as they arrive. The non-maskable pin is asynchronous, so it passes through a two-flop synchronizer. After that, the pin and the stack-overflow input are reduced to rising edges, and only those edges set a pending flag. A fixed priority picks one pending flag to present. The global interrupt-enable state reaches the unit but has no influence on it. None of these events can be diverted to a transaction server. Once the illegal-opcode request is taken, the unit stays silent until the CPU reports one more instruction boundary.

Top module: `nmi_special_irq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `req_o` is 0 and no event is pending.
- R2: A one-cycle `illop_stb_i` sampled at a clock edge makes `req_o` 1 with `vec_o` = 24'hFF2012 from that edge onward.
- R3: A `trap_stb_i` sampled at an edge makes `req_o` 1 with `vec_o` = `TRAP_VEC` (24'hFF2010 by default) from that edge onward, provided nothing of higher priority is pending.
- R4: A rising edge of `nmi_pin_i` sets NMI pending on the third clock edge after the pin goes high. A pin held high produces exactly one request. The vector is `NMI_VEC` (24'hFF203E by default).
- R5: A rising edge of `stkovf_i`, sampled at a clock edge, sets stack-overflow pending at that same edge. An input held high produces exactly one request. The vector is `STK_VEC` (24'hFF203C by default).
- R6: When several events are pending, `vec_o` follows a fixed priority: illegal opcode first, then trap, then NMI, then stack overflow.
- R7: An edge with `req_o` and `ack_i` both 1 clears only the source being presented. The other pending sources stay pending. A new event from that same source in the same cycle stays pending.
- R8: Acknowledging the illegal-opcode request holds `req_o` at 0 until `insn_done_i` has been sampled at a clock edge. `req_o` can be 1 again from that edge onward.
- R9: `int_en_i` has no effect on `req_o`, on `vec_o` or on pending state.
- R10: `ack_i` sampled while `req_o` is 0, including during the lockout, clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin_i | input | 1 | Asynchronous non-maskable interrupt pin level |
| stkovf_i | input | 1 | Stack-overflow indication, synchronous |
| illop_stb_i | input | 1 | Decoder strobe: unimplemented opcode |
| trap_stb_i | input | 1 | Decoder strobe: software trap instruction |
| int_en_i | input | 1 | Global interrupt-enable state (ignored) |
| insn_done_i | input | 1 | Instruction-boundary strobe |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| req_o | output | 1 | Service request |
| vec_o | output | 24 | Vector fetch address of the presented request |

## Verification
The hardest state to reach is a lockout window during which other sources are already pending and the CPU keeps acknowledging. In that state a faulty unit would either present a request too early or silently drop a source. The stimulus builds this state on purpose. It sets stack-overflow pending and fires an illegal-opcode strobe in the same cycle. It then holds the acknowledge high across the whole window and raises the boundary strobe only later. A long random phase then mixes strobes, pin edges, enable toggles and acknowledges. The behavioural model checks every cycle.

// File: rtl/nmi_spec_pkg.sv
package nmi_spec_pkg;
    localparam int NUM_SRC = 4;
    localparam int VEC_W   = 24;
    localparam logic [VEC_W-1:0] ILLOP_VEC = 24'hFF2012;

    // Index order is priority order: lowest index wins
    typedef enum logic [1:0] {
        SRC_ILLOP = 2'd0,
        SRC_TRAP  = 2'd1,
        SRC_NMI   = 2'd2,
        SRC_STK   = 2'd3
    } src_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               lock;
    } core_state_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    generate
        if (STAGES == 0) begin : g_direct
            logic prev_d, prev_q;
            always_comb prev_d = din;
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= prev_d;
            end
            assign rise_o = din & ~prev_q;
        end else begin : g_sync
            // STAGES synchronizer flops plus one history flop
            logic [STAGES:0] sh_d, sh_q;
            always_comb sh_d = {sh_q[STAGES-1:0], din};
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end
            assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
        end
    endgenerate

    // R4 R5: a level held high yields one edge only
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import nmi_spec_pkg::*;
#(
    parameter logic [VEC_W-1:0] TRAP_VEC = 24'hFF2010,
    parameter logic [VEC_W-1:0] NMI_VEC  = 24'hFF203E,
    parameter logic [VEC_W-1:0] STK_VEC  = 24'hFF203C
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               any_o,
    output src_e               sel_o,
    output logic [VEC_W-1:0]   vec_o
);
    always_comb begin
        any_o = |pend_i;
        sel_o = SRC_STK;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) sel_o = src_e'(i);
        end
        unique case (sel_o)
            SRC_ILLOP: vec_o = ILLOP_VEC;
            SRC_TRAP:  vec_o = TRAP_VEC;
            SRC_NMI:   vec_o = NMI_VEC;
            default:   vec_o = STK_VEC;
        endcase
    end
endmodule

// File: rtl/nmi_special_irq.sv
module nmi_special_irq
    import nmi_spec_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [VEC_W-1:0] TRAP_VEC    = 24'hFF2010,
    parameter logic [VEC_W-1:0] NMI_VEC     = 24'hFF203E,
    parameter logic [VEC_W-1:0] STK_VEC     = 24'hFF203C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin_i,
    input  logic             stkovf_i,
    input  logic             illop_stb_i,
    input  logic             trap_stb_i,
    input  logic             int_en_i,
    input  logic             insn_done_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o
);
    core_state_t st_d, st_q;
    logic        nmi_rise, stk_rise, any_pend, taken;
    logic [NUM_SRC-1:0] set_vec, clr_vec;
    src_e        sel;

    edge_sync #(.STAGES(SYNC_STAGES)) i_nmi_edge (
        .clk(clk), .rst_n(rst_n), .din(nmi_pin_i), .rise_o(nmi_rise));

    edge_sync #(.STAGES(0)) i_stk_edge (
        .clk(clk), .rst_n(rst_n), .din(stkovf_i), .rise_o(stk_rise));

    irq_prio_pick #(.TRAP_VEC(TRAP_VEC), .NMI_VEC(NMI_VEC), .STK_VEC(STK_VEC)) i_pick (
        .pend_i(st_q.pend), .any_o(any_pend), .sel_o(sel), .vec_o(vec_o));

    assign req_o = any_pend & ~st_q.lock;
    assign taken = req_o & ack_i;

    always_comb begin
        st_d    = st_q;
        set_vec = '0;
        set_vec[SRC_ILLOP] = illop_stb_i;
        set_vec[SRC_TRAP]  = trap_stb_i;
        set_vec[SRC_NMI]   = nmi_rise;
        set_vec[SRC_STK]   = stk_rise;
        clr_vec = '0;
        if (taken) clr_vec[sel] = 1'b1;
        st_d.pend = (st_q.pend & ~clr_vec) | set_vec;
        if (taken && sel == SRC_ILLOP) st_d.lock = 1'b1;
        else if (insn_done_i)          st_d.lock = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    illop_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illop_stb_i |=> st_q.pend[SRC_ILLOP]);
    // R6
    illop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && st_q.pend[SRC_ILLOP]) |-> (vec_o == ILLOP_VEC));
    // R8
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && vec_o == ILLOP_VEC) |=> !req_o);
    // R9
    enable_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en_i && |st_q.pend && !st_q.lock) |-> req_o);
    // R10
    no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_o && ack_i) |=> ((st_q.pend & $past(st_q.pend)) == $past(st_q.pend)));
endmodule

// File: tb/test_nmi_special_irq.sv
`timescale 1ns/1ps
module test_nmi_special_irq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi = 1'b0, stk = 1'b0, illop = 1'b0, trap = 1'b0;
    logic en = 1'b0, done = 1'b0, ack = 1'b0;
    logic req;
    logic [23:0] vec;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    nmi_special_irq #(.TRAP_VEC(24'hFF2010), .NMI_VEC(24'hFF203E), .STK_VEC(24'hFF203C))
    i_nmi_special_irq (
        .clk(clk), .rst_n(rst_n), .nmi_pin_i(nmi), .stkovf_i(stk),
        .illop_stb_i(illop), .trap_stb_i(trap), .int_en_i(en),
        .insn_done_i(done), .ack_i(ack), .req_o(req), .vec_o(vec));

    // Behavioural reference model
    bit m_pend [4];
    bit m_lock;
    bit m_stk_last;
    bit nmi_hist [$];

    function automatic int m_top();
        for (int i = 0; i < 4; i++) if (m_pend[i]) return i;
        return -1;
    endfunction

    function automatic logic [23:0] vec_of(int s);
        case (s)
            0: return 24'hFF2012;
            1: return 24'hFF2010;
            2: return 24'hFF203E;
            default: return 24'hFF203C;
        endcase
    endfunction

    function automatic bit m_req();
        return (m_top() >= 0) && !m_lock;
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 0;
            m_lock = 0; m_stk_last = 0;
            nmi_hist = '{0, 0, 0};
        end else begin
            int s;
            bit n_rise;
            s = m_top();
            if (m_req() && ack) begin
                m_pend[s] = 0;
                if (s == 0) m_lock = 1;
                else if (done) m_lock = 0;
            end else if (done) m_lock = 0;
            n_rise = nmi_hist[1] && !nmi_hist[2];
            if (illop) m_pend[0] = 1;
            if (trap) m_pend[1] = 1;
            if (n_rise) m_pend[2] = 1;
            if (stk && !m_stk_last) m_pend[3] = 1;
            m_stk_last = stk;
            nmi_hist.push_front(nmi);
            void'(nmi_hist.pop_back());
        end
    endtask

    task automatic check(bit ok, string t, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        model_step();
        check(req === m_req(), tag, {31'd0, req}, {31'd0, m_req()});
        if (m_req()) check(vec === vec_of(m_top()), tag, {8'd0, vec}, {8'd0, vec_of(m_top())});
    endtask

    task automatic expect_out(bit r, logic [23:0] v, string t);
        check(req === r, t, {31'd0, req}, {31'd0, r});
        if (r) check(vec === v, t, {8'd0, vec}, {8'd0, v});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        nmi_hist = '{0, 0, 0};
        tag = "R1";
        repeat (3) tick();
        expect_out(0, 0, "R1");
        rst_n = 1;
        tick();
        expect_out(0, 0, "R1");

        // R2 then R8 lockout with trap waiting
        tag = "R2";
        illop = 1; tick(); illop = 0;
        expect_out(1, 24'hFF2012, "R2");
        tag = "R8";
        ack = 1; trap = 1; tick(); ack = 0; trap = 0;
        expect_out(0, 0, "R8");
        repeat (3) tick();
        expect_out(0, 0, "R8");
        done = 1; tick(); done = 0;
        expect_out(1, 24'hFF2010, "R8");
        ack = 1; tick(); ack = 0;
        expect_out(0, 0, "R7");

        // R3 and R9: trap with enable low and high
        tag = "R3";
        en = 0; trap = 1; tick(); trap = 0;
        expect_out(1, 24'hFF2010, "R9");
        en = 1; tick();
        expect_out(1, 24'hFF2010, "R3");
        ack = 1; tick(); ack = 0;

        // R4: synchronized NMI, one request for a held level
        tag = "R4";
        nmi = 1; tick(); expect_out(0, 0, "R4");
        tick(); expect_out(0, 0, "R4");
        tick(); expect_out(1, 24'hFF203E, "R4");
        ack = 1; tick(); ack = 0;
        repeat (8) tick();
        expect_out(0, 0, "R4");
        nmi = 0;

        // R5: stack overflow held high
        tag = "R5";
        stk = 1; tick();
        expect_out(1, 24'hFF203C, "R5");
        ack = 1; tick(); ack = 0;
        repeat (6) tick();
        expect_out(0, 0, "R5");
        stk = 0; tick();

        // R6 and R7: all four pending
        tag = "R6";
        nmi = 1; stk = 1; repeat (3) tick();
        illop = 1; trap = 1; tick(); illop = 0; trap = 0;
        expect_out(1, 24'hFF2012, "R6");
        ack = 1; tick(); ack = 0;
        done = 1; tick(); done = 0;
        expect_out(1, 24'hFF2010, "R6");
        ack = 1; tick(); ack = 0;
        expect_out(1, 24'hFF203E, "R7");
        ack = 1; tick(); ack = 0;
        expect_out(1, 24'hFF203C, "R7");
        ack = 1; tick(); ack = 0;
        expect_out(0, 0, "R7");
        nmi = 0; stk = 0; tick();

        // R7: a new event from the same source as the acknowledge survives
        tag = "R7";
        trap = 1; tick();
        ack = 1; tick(); ack = 0; trap = 0;
        expect_out(1, 24'hFF2010, "R7");
        ack = 1; tick(); ack = 0;
        expect_out(0, 0, "R7");

        // R10: ack with nothing pending, ack during lockout
        tag = "R10";
        ack = 1; repeat (3) tick(); ack = 0;
        expect_out(0, 0, "R10");
        illop = 1; stk = 1; tick(); illop = 0;
        ack = 1; repeat (4) tick(); ack = 0;
        expect_out(0, 0, "R10");
        done = 1; tick(); done = 0;
        expect_out(1, 24'hFF203C, "R10");
        ack = 1; tick(); ack = 0; stk = 0;
        tick();

        // Random mix, compared against the model every cycle
        tag = "R9";
        for (int k = 0; k < 4000; k++) begin
            illop = ($urandom_range(0, 19) == 0);
            trap  = ($urandom_range(0, 14) == 0);
            if ($urandom_range(0, 9) == 0) nmi = ~nmi;
            if ($urandom_range(0, 7) == 0) stk = ~stk;
            en    = $urandom_range(0, 1);
            done  = ($urandom_range(0, 3) == 0);
            ack   = ($urandom_range(0, 2) == 0);
            tick();
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule